// File: doc/BRIEF.md
# Packed Multiply-Add and Absolute-Difference Unit

This block is a registered SIMD arithmetic stage for a 64-bit media datapath. It takes two 64-bit operand words and a 4-bit operation code, and returns one 64-bit result. Depending on the code, it views each operand either as four 16-bit lanes or as eight 8-bit lanes.

Halfword lane k occupies bits 16k+15 down to 16k, and byte lane k occupies bits 8k+7 down to 8k. The available operations are:

- pairwise multiply-add into two 32-bit halves;
- per-lane 16x16 multiply that keeps either the lower or the upper half of each product;
- a four-lane multiply-accumulate folded into one 64-bit value;
- sums of absolute differences over bytes or over halfwords.

All of the arithmetic is combinational and feeds a single output register. An input strobe produces an output strobe on the following cycle. The unit keeps no other state. Saturation and condition flags are handled elsewhere.

Top module: `pmac_sad_unit`

## Requirements
- R1: Code 0 (signed pairwise multiply-add): each 16-bit lane is sign-extended and multiplied by the matching lane of the other operand. Bits 31:0 of the result hold the low 32 bits of product0+product1. Bits 63:32 hold the low 32 bits of product2+product3.
- R2: Code 1 (unsigned pairwise multiply-add): the same lane pairing and placement as R1, with the lanes zero-extended before multiplying.
- R3: Code 2 (byte SAD): the result is the sum of the eight unsigned byte absolute differences, zero-extended to 64 bits.
- R4: Code 3 (halfword SAD): the result is the sum of the four unsigned 16-bit absolute differences, zero-extended to 64 bits.
- R5: Codes 4 to 7 (lane multiply): each 16-bit lane of the result holds 16 bits of the full 32-bit product of that lane pair, placed in the same lane position. The code selects the variant:
  - 4: signed, product bits 15:0;
  - 5: signed, product bits 31:16;
  - 6: unsigned, product bits 15:0;
  - 7: unsigned, product bits 31:16.
- R6: Code 8 (signed multiply-accumulate): the result is the exact sum of the four signed lane products, sign-extended to 64 bits.
- R7: Code 9 (unsigned multiply-accumulate): the result is the exact sum of the four unsigned lane products, zero-extended to 64 bits.
- R8: Codes 10 to 15 produce an all-zero result.
- R9: `out_valid` equals the `in_valid` value sampled at the previous rising clock edge.
- R10: `res_o` loads a new value only on an edge where `in_valid` is high. Otherwise it holds its previous value.
- R11: While `rst` is high at a rising edge, `res_o` and `out_valid` are both cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_o | output | 64 | Registered result |

## Verification
The width assertions on SAD and multiply-accumulate results assume that every lane is a full-range 16-bit or 8-bit value. They also assume that `op_i` is stable within the cycle in which `in_valid` is sampled. The stimulus satisfies both: it drives operands and code only at the falling edge.

The random part draws all 16 codes, including the unused ones. It mixes uniform random lanes with lanes forced to 0x8000, 0xFFFF, 0x7FFF and 0x0000, so that the extreme signed and unsigned products and the largest SAD sums are all reached. Gaps with `in_valid` low are inserted on purpose, so that the hold behaviour is observed at the output.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    localparam int WORD_W = 64;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_HALF = WORD_W / HALF_W;
    localparam int N_BYTE = WORD_W / BYTE_W;
    localparam int N_PAIR = N_HALF / 2;
    localparam int PAIR_W = 2 * HALF_W;
    localparam int OPND_W = HALF_W + 1;
    localparam int PROD_W = 2 * OPND_W;
    localparam int MAC_W  = PROD_W + $clog2(N_HALF);
    localparam int SADB_W = BYTE_W + $clog2(N_BYTE);
    localparam int SADH_W = HALF_W + $clog2(N_HALF);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MADD_S = 4'd0,
        OP_MADD_U = 4'd1,
        OP_SAD_B  = 4'd2,
        OP_SAD_H  = 4'd3,
        OP_MUL_SL = 4'd4,
        OP_MUL_SH = 4'd5,
        OP_MUL_UL = 4'd6,
        OP_MUL_UH = 4'd7,
        OP_MAC_S  = 4'd8,
        OP_MAC_U  = 4'd9
    } op_e;

    typedef logic [N_HALF-1:0][PROD_W-1:0] prod_vec_t;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
    } opnd_pair_t;

    function automatic logic [OPND_W-1:0] widen_half(input logic [HALF_W-1:0] x,
                                                     input logic sgn);
        return {sgn & x[HALF_W-1], x};
    endfunction

    function automatic logic op_is_signed(input op_e op);
        return (op == OP_MADD_S) || (op == OP_MUL_SL) ||
               (op == OP_MUL_SH) || (op == OP_MAC_S);
    endfunction

endpackage

// File: rtl/pmac_mul_array.sv
module pmac_mul_array
    import pmac_pkg::*;
#(
    parameter int LANE_W = HALF_W,
    parameter int LANES  = N_HALF
) (
    input  opnd_pair_t opnd_i,
    input  logic       sgn_i,
    output prod_vec_t  prod_o
);
    localparam int EXT_W = LANE_W + 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [EXT_W-1:0] xa;
        logic signed [EXT_W-1:0] xb;
        assign xa = widen_half(opnd_i.a[k*LANE_W +: LANE_W], sgn_i);
        assign xb = widen_half(opnd_i.b[k*LANE_W +: LANE_W], sgn_i);
        // a 17x17 signed product fits exactly in 34 bits
        assign prod_o[k] = xa * xb;
    end
endmodule

// File: rtl/pmac_sad.sv
module pmac_sad
    import pmac_pkg::*;
#(
    parameter int LANE_W = BYTE_W,
    parameter int LANES  = N_BYTE,
    parameter int SUM_W  = LANE_W + $clog2(LANES)
) (
    input  opnd_pair_t        opnd_i,
    output logic [SUM_W-1:0]  sum_o
);
    logic [LANES-1:0][LANE_W-1:0] diff;

    for (genvar k = 0; k < LANES; k++) begin : g_diff
        logic [LANE_W-1:0] xa;
        logic [LANE_W-1:0] xb;
        assign xa = opnd_i.a[k*LANE_W +: LANE_W];
        assign xb = opnd_i.b[k*LANE_W +: LANE_W];
        assign diff[k] = (xa >= xb) ? (xa - xb) : (xb - xa);
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < LANES; k++) begin
            sum_o = sum_o + SUM_W'(diff[k]);
        end
    end
endmodule

// File: rtl/pmac_combine.sv
module pmac_combine
    import pmac_pkg::*;
(
    input  op_e                op_i,
    input  prod_vec_t          prod_i,
    input  logic [SADB_W-1:0]  sadb_i,
    input  logic [SADH_W-1:0]  sadh_i,
    output logic [WORD_W-1:0]  res_o
);
    logic [WORD_W-1:0] madd_w;
    logic [WORD_W-1:0] mul_lo_w;
    logic [WORD_W-1:0] mul_hi_w;
    logic [MAC_W-1:0]  mac_acc;
    logic [WORD_W-1:0] mac_w;

    // pairwise sums: only the low PAIR_W bits of each sum are kept
    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
        logic [PROD_W-1:0] psum;
        assign psum = prod_i[2*j] + prod_i[2*j+1];
        assign madd_w[j*PAIR_W +: PAIR_W] = psum[PAIR_W-1:0];
    end

    // per-lane product halves, returned in their own lane
    for (genvar k = 0; k < N_HALF; k++) begin : g_lane
        assign mul_lo_w[k*HALF_W +: HALF_W] = prod_i[k][HALF_W-1:0];
        assign mul_hi_w[k*HALF_W +: HALF_W] = prod_i[k][PAIR_W-1:HALF_W];
    end

    // horizontal reduction at full precision
    always_comb begin
        mac_acc = '0;
        for (int k = 0; k < N_HALF; k++) begin
            mac_acc = mac_acc + {{(MAC_W-PROD_W){prod_i[k][PROD_W-1]}}, prod_i[k]};
        end
    end
    assign mac_w = {{(WORD_W-MAC_W){mac_acc[MAC_W-1]}}, mac_acc};

    always_comb begin
        unique case (op_i)
            OP_MADD_S, OP_MADD_U: res_o = madd_w;
            OP_SAD_B:             res_o = WORD_W'(sadb_i);
            OP_SAD_H:             res_o = WORD_W'(sadh_i);
            OP_MUL_SL, OP_MUL_UL: res_o = mul_lo_w;
            OP_MUL_SH, OP_MUL_UH: res_o = mul_hi_w;
            OP_MAC_S, OP_MAC_U:   res_o = mac_w;
            default:              res_o = '0;
        endcase
    end
endmodule

// File: rtl/pmac_sad_unit.sv
module pmac_sad_unit
    import pmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_o
);
    op_e               op;
    opnd_pair_t        opnd;
    prod_vec_t         prod;
    logic [SADB_W-1:0] sadb;
    logic [SADH_W-1:0] sadh;
    logic [WORD_W-1:0] res_d;

    assign op   = op_e'(op_i);
    assign opnd = '{a: a_i, b: b_i};

    pmac_mul_array #(.LANE_W(HALF_W), .LANES(N_HALF)) u_mul (
        .opnd_i (opnd),
        .sgn_i  (op_is_signed(op)),
        .prod_o (prod)
    );

    pmac_sad #(.LANE_W(BYTE_W), .LANES(N_BYTE), .SUM_W(SADB_W)) u_sad_b (
        .opnd_i (opnd),
        .sum_o  (sadb)
    );

    pmac_sad #(.LANE_W(HALF_W), .LANES(N_HALF), .SUM_W(SADH_W)) u_sad_h (
        .opnd_i (opnd),
        .sum_o  (sadh)
    );

    pmac_combine u_comb (
        .op_i   (op),
        .prod_i (prod),
        .sadb_i (sadb),
        .sadh_i (sadh),
        .res_o  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_o <= res_d;
            end
        end
    end

    // R9: output strobe trails the input strobe by one edge
    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R10: no load without an input strobe
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_o));

    // R3: byte SAD never reaches above its sum width
    assert_sadb_width_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd2) |=> (res_o[WORD_W-1:SADB_W] == '0));

    // R4: halfword SAD never reaches above its sum width
    assert_sadh_width_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd3) |=> (res_o[WORD_W-1:SADH_W] == '0));

    // R7: unsigned accumulation stays non-negative and narrow
    assert_macu_width_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd9) |=> (res_o[WORD_W-1:PROD_W] == '0));

    // R6: signed accumulation is a sign extension above its width
    assert_macs_ext_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd8) |=>
        ((res_o[WORD_W-1:PROD_W] == '0) || (res_o[WORD_W-1:PROD_W] == '1)));

    // R8: unused codes load zero
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i > 4'd9) |=> (res_o == '0));
endmodule

// File: tb/pmac_sad_unit_tb_top.sv
`timescale 1ns/1ps
module pmac_sad_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        out_valid;
    logic [63:0] res_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pmac_sad_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .out_valid(out_valid), .res_o(res_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd8: return "R6";
            4'd9: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [63:0] ref_model(input logic [3:0] op,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
        longint      p [4];
        logic [63:0] pv;
        logic [63:0] r;
        longint      acc;
        bit          sgn;
        sgn = (op == 0) || (op == 4) || (op == 5) || (op == 8);
        for (int k = 0; k < 4; k++) begin
            if (sgn) p[k] = longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
            else     p[k] = longint'(a[16*k +: 16]) * longint'(b[16*k +: 16]);
        end
        r = '0;
        case (op)
            4'd0, 4'd1: begin
                pv = 64'(p[0] + p[1]); r[31:0]  = pv[31:0];
                pv = 64'(p[2] + p[3]); r[63:32] = pv[31:0];
            end
            4'd2: begin
                acc = 0;
                for (int k = 0; k < 8; k++) begin
                    int d;
                    d = int'(a[8*k +: 8]) - int'(b[8*k +: 8]);
                    acc += (d < 0) ? -d : d;
                end
                r = 64'(acc);
            end
            4'd3: begin
                acc = 0;
                for (int k = 0; k < 4; k++) begin
                    int d;
                    d = int'(a[16*k +: 16]) - int'(b[16*k +: 16]);
                    acc += (d < 0) ? -d : d;
                end
                r = 64'(acc);
            end
            4'd4, 4'd5, 4'd6, 4'd7: begin
                for (int k = 0; k < 4; k++) begin
                    pv = 64'(p[k]);
                    r[16*k +: 16] = (op == 5 || op == 7) ? pv[31:16] : pv[15:0];
                end
            end
            4'd8, 4'd9: r = 64'(p[0] + p[1] + p[2] + p[3]);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at falling edge, result visible one rising edge later
    task automatic apply(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req_of(op), "result", res_o, ref_model(op, a, b));
        check("R9", "valid strobe", 64'(out_valid), 64'd1);
    endtask

    function automatic logic [15:0] pick_lane();
        case ($urandom % 6)
            0: return 16'h8000;
            1: return 16'hFFFF;
            2: return 16'h7FFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [63:0] rand_word();
        logic [63:0] w;
        if ($urandom % 2) w = {$urandom, $urandom};
        else for (int k = 0; k < 4; k++) w[16*k +: 16] = pick_lane();
        return w;
    endfunction

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset result", res_o, 64'd0);
        check("R11", "reset valid", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // directed corners for every code
        for (int op = 0; op < 16; op++) begin
            apply(4'(op), {4{16'h8000}}, {4{16'h8000}});
            apply(4'(op), {4{16'hFFFF}}, {4{16'hFFFF}});
            apply(4'(op), {4{16'h8000}}, {4{16'h7FFF}});
            apply(4'(op), {4{16'hFFFF}}, 64'd0);
            apply(4'(op), 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        end

        // R10: idle cycle with changed inputs leaves the result alone
        apply(4'd0, 64'h0003_0002_0001_0004, 64'h0005_0006_0007_0008);
        held = res_o;
        @(negedge clk);
        op_i = 4'd2; a_i = '1; b_i = '0; in_valid = 1'b0;
        @(negedge clk);
        check("R10", "hold on idle", res_o, held);
        check("R9", "no strobe on idle", 64'(out_valid), 64'd0);

        // random mix with occasional idle gaps
        for (int i = 0; i < 3000; i++) begin
            apply(4'($urandom % 16), rand_word(), rand_word());
            if ($urandom % 8 == 0) begin
                held = res_o;
                @(negedge clk);
                a_i = rand_word(); op_i = 4'($urandom % 16);
                @(negedge clk);
                check("R10", "hold on random idle", res_o, held);
                check("R9", "strobe low after idle", 64'(out_valid), 64'd0);
            end
        end

        // R11: reset in the middle of traffic
        @(negedge clk);
        op_i = 4'd1; a_i = '1; b_i = '1; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R11", "mid-run reset result", res_o, 64'd0);
        check("R11", "mid-run reset valid", 64'(out_valid), 64'd0);
        in_valid = 1'b0; rst = 1'b0;
        apply(4'd8, {4{16'h8000}}, {4{16'h7FFF}});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule